// File: doc/BRIEF.md
# CAN Receive Mailbox Matcher

This block keeps a bank of receive mailboxes for a CAN controller. Each mailbox holds a 4-bit state code, a format flag (standard or extended) and a 29-bit identifier. Each mailbox also holds the last payload it accepted: the length code and eight data bytes. The host programs the state code, the format flag and the identifier through a simple write port. A programmable limit sets the highest mailbox index that takes part in matching.

When the CAN receiver presents a frame that was received without error, the block compares it with every eligible mailbox in parallel. It stores the frame in the lowest-indexed mailbox that matches and moves that mailbox's state code forward. It then reports either a one-cycle hit pulse with the winning index or a one-cycle miss pulse. A frame flagged as erroneous is dropped silently. A combinational read port exposes any mailbox's stored contents. Every mailbox's state code is also visible at all times.

Top module: `rx_mailbox_matcher`

## Requirements
- R1: After reset every mailbox code is INACTIVE (4'b0000), and neither the hit pulse nor the miss pulse is asserted.
- R2: A frame strobe with the error flag set causes no search. It raises no hit or miss pulse and changes no mailbox. A hit or miss pulse only follows an error-free frame strobe.
- R3: Only mailboxes coded EMPTY (4'b0100), FULL (4'b0010) or OVERRUN (4'b0110) can match. INACTIVE (4'b0000) and any code with bit 3 set (transmit) never match.
- R4: Mailboxes whose index is greater than `cfg_last_idx_i` never match. The mailbox at exactly that index still takes part.
- R5: When several eligible mailboxes match, the frame goes to the one with the lowest index.
- R6: For a standard frame, only identifier bits 28 down to 18 are compared. Bits 17 down to 0 are ignored.
- R7: For an extended frame, all 29 identifier bits must be equal.
- R8: A mailbox matches only if its format flag (1 = extended) equals the frame's format flag.
- R9: On a hit, the winner's code goes from EMPTY to FULL, and from FULL or OVERRUN to OVERRUN.
- R10: On a hit, the winner stores the frame's identifier, length code and 64-bit data. The read port returns these through `rd_idx_i`.
- R11: For a frame strobe sampled at clock edge k, exactly one of hit or miss is high for the single cycle after edge k+1. A miss changes no mailbox code. Strobes may arrive on consecutive cycles.
- R12: A host write sampled at a frame-strobe edge, or while a search is in flight, is held back. It is applied at the first edge with no search in flight, after the search's result has been written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_last_idx_i | input | IW | Highest mailbox index that takes part in matching |
| host_wr_en_i | input | 1 | Host write strobe |
| host_wr_idx_i | input | IW | Mailbox written by the host |
| host_wr_code_i | input | 4 | State code to write |
| host_wr_ext_i | input | 1 | Format flag to write (1 = extended) |
| host_wr_id_i | input | 29 | Identifier to write |
| rx_valid_i | input | 1 | Received-frame strobe |
| rx_err_i | input | 1 | Frame had an error; do not search |
| rx_ext_i | input | 1 | Frame format (1 = extended) |
| rx_id_i | input | 29 | Frame identifier |
| rx_dlc_i | input | 4 | Frame length code |
| rx_data_i | input | 64 | Frame data bytes |
| rd_idx_i | input | IW | Mailbox selected for read-back |
| rd_ext_o | output | 1 | Format flag of the selected mailbox |
| rd_id_o | output | 29 | Identifier of the selected mailbox |
| rd_dlc_o | output | 4 | Stored length code of the selected mailbox |
| rd_data_o | output | 64 | Stored data of the selected mailbox |
| hit_o | output | 1 | One-cycle pulse: frame stored |
| miss_o | output | 1 | One-cycle pulse: frame discarded |
| hit_idx_o | output | IW | Index of the mailbox that took the frame |
| buf_code_o | output | 4*NUM_BUF | State code of every mailbox, mailbox i at bits 4i+3..4i |

## Verification
The bench aims at the matching corners:
- Two standard mailboxes share the upper identifier bits, so a design that does not give priority to the lowest index would report the wrong index.
- A standard frame differs only in its low 18 bits, and an extended frame in a single low bit, so a comparison of the wrong width would turn a hit into a miss or a miss into a hit.
- Frames whose identifier matches a mailbox of the opposite format, a transmit mailbox or an inactive mailbox must miss.
- The limit is moved to just below and exactly onto a matching mailbox, so an off-by-one comparison would show up.
- A host write that lands together with a frame strobe must not change that search. A design that applied the write at once would miss a frame it should catch, or would overwrite the result.
- Back-to-back strobes must see each other's state updates.

// File: rtl/rxmb_pkg.sv
package rxmb_pkg;

    localparam int ID_W   = 29;
    localparam int STD_W  = 11;
    localparam int DLC_W  = 4;
    localparam int DATA_W = 64;
    localparam int CODE_W = 4;

    localparam logic [CODE_W-1:0] CODE_INACTIVE = 4'b0000;
    localparam logic [CODE_W-1:0] CODE_EMPTY    = 4'b0100;
    localparam logic [CODE_W-1:0] CODE_FULL     = 4'b0010;
    localparam logic [CODE_W-1:0] CODE_OVERRUN  = 4'b0110;

    // frame captured from the receiver
    typedef struct packed {
        logic              ext;
        logic [ID_W-1:0]   id;
        logic [DLC_W-1:0]  dlc;
        logic [DATA_W-1:0] data;
    } frame_t;

    // one mailbox entry
    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic              ext;
        logic [ID_W-1:0]   id;
        logic [DLC_W-1:0]  dlc;
        logic [DATA_W-1:0] data;
    } mbox_t;

    // host programming payload
    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic              ext;
        logic [ID_W-1:0]   id;
    } hwr_t;

    function automatic logic code_is_rx_live(input logic [CODE_W-1:0] c);
        return (c == CODE_EMPTY) || (c == CODE_FULL) || (c == CODE_OVERRUN);
    endfunction

    function automatic logic [CODE_W-1:0] code_after_hit(input logic [CODE_W-1:0] c);
        return (c == CODE_EMPTY) ? CODE_FULL : CODE_OVERRUN;
    endfunction

endpackage

// File: rtl/rxmb_cmp.sv
module rxmb_cmp
    import rxmb_pkg::*;
(
    input  logic              in_range_i,
    input  logic [CODE_W-1:0] mb_code_i,
    input  logic              mb_ext_i,
    input  logic [ID_W-1:0]   mb_id_i,
    input  logic              frm_ext_i,
    input  logic [ID_W-1:0]   frm_id_i,
    output logic              match_o
);

    logic id_eq;
    logic live;

    always_comb begin
        if (mb_ext_i) begin
            id_eq = (mb_id_i == frm_id_i);
        end else begin
            id_eq = (mb_id_i[ID_W-1 -: STD_W] == frm_id_i[ID_W-1 -: STD_W]);
        end
        live    = code_is_rx_live(mb_code_i);
        match_o = in_range_i && live && (mb_ext_i == frm_ext_i) && id_eq;
    end

endmodule

// File: rtl/rxmb_prio.sv
module rxmb_prio #(
    parameter int N  = 64,
    parameter int IW = 6
) (
    input  logic [N-1:0]  vec_i,
    output logic          any_o,
    output logic [IW-1:0] idx_o
);

    always_comb begin
        any_o = |vec_i;
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec_i[i]) begin
                idx_o = IW'(i);
            end
        end
    end

endmodule

// File: rtl/rx_mailbox_matcher.sv
module rx_mailbox_matcher
    import rxmb_pkg::*;
#(
    parameter  int NUM_BUF = 64,
    localparam int IW      = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [IW-1:0]         cfg_last_idx_i,
    input  logic                  host_wr_en_i,
    input  logic [IW-1:0]         host_wr_idx_i,
    input  logic [3:0]            host_wr_code_i,
    input  logic                  host_wr_ext_i,
    input  logic [28:0]           host_wr_id_i,
    input  logic                  rx_valid_i,
    input  logic                  rx_err_i,
    input  logic                  rx_ext_i,
    input  logic [28:0]           rx_id_i,
    input  logic [3:0]            rx_dlc_i,
    input  logic [63:0]           rx_data_i,
    input  logic [IW-1:0]         rd_idx_i,
    output logic                  rd_ext_o,
    output logic [28:0]           rd_id_o,
    output logic [3:0]            rd_dlc_o,
    output logic [63:0]           rd_data_o,
    output logic                  hit_o,
    output logic                  miss_o,
    output logic [IW-1:0]         hit_idx_o,
    output logic [NUM_BUF*4-1:0]  buf_code_o
);

    typedef struct packed {
        mbox_t [NUM_BUF-1:0] bank;
        logic                srch_vld;
        frame_t              frm;
        logic                pend_vld;
        logic [IW-1:0]       pend_idx;
        hwr_t                pend;
        logic                hit;
        logic                miss;
        logic [IW-1:0]       hit_idx;
    } state_t;

    state_t st_d, st_q;

    logic [NUM_BUF-1:0] match_vec;
    logic               any_match;
    logic [IW-1:0]      win_idx;

    // parallel comparators, one per mailbox
    for (genvar g = 0; g < NUM_BUF; g++) begin : g_cmp
        localparam logic [IW-1:0] MY_IDX = IW'(g);
        logic in_range;
        assign in_range = (MY_IDX <= cfg_last_idx_i);

        rxmb_cmp u_cmp (
            .in_range_i (in_range),
            .mb_code_i  (st_q.bank[g].code),
            .mb_ext_i   (st_q.bank[g].ext),
            .mb_id_i    (st_q.bank[g].id),
            .frm_ext_i  (st_q.frm.ext),
            .frm_id_i   (st_q.frm.id),
            .match_o    (match_vec[g])
        );

        assign buf_code_o[g*4 +: 4] = st_q.bank[g].code;
    end

    rxmb_prio #(
        .N  (NUM_BUF),
        .IW (IW)
    ) u_prio (
        .vec_i (match_vec),
        .any_o (any_match),
        .idx_o (win_idx)
    );

    logic accept;
    logic hold_host;

    always_comb begin
        st_d      = st_q;
        st_d.hit  = 1'b0;
        st_d.miss = 1'b0;

        // result stage: frame captured last edge is stored now
        if (st_q.srch_vld) begin
            if (any_match) begin
                st_d.bank[win_idx].code = code_after_hit(st_q.bank[win_idx].code);
                st_d.bank[win_idx].id   = st_q.frm.id;
                st_d.bank[win_idx].dlc  = st_q.frm.dlc;
                st_d.bank[win_idx].data = st_q.frm.data;
                st_d.hit                = 1'b1;
                st_d.hit_idx            = win_idx;
            end else begin
                st_d.miss = 1'b1;
            end
        end

        // capture stage
        accept        = rx_valid_i && !rx_err_i;
        st_d.srch_vld = accept;
        if (accept) begin
            st_d.frm.ext  = rx_ext_i;
            st_d.frm.id   = rx_id_i;
            st_d.frm.dlc  = rx_dlc_i;
            st_d.frm.data = rx_data_i;
        end

        // host programming, deferred across a search
        hold_host = st_q.srch_vld || accept;
        if (hold_host) begin
            if (host_wr_en_i) begin
                st_d.pend_vld  = 1'b1;
                st_d.pend_idx  = host_wr_idx_i;
                st_d.pend.code = host_wr_code_i;
                st_d.pend.ext  = host_wr_ext_i;
                st_d.pend.id   = host_wr_id_i;
            end
        end else begin
            if (st_q.pend_vld) begin
                st_d.bank[st_q.pend_idx].code = st_q.pend.code;
                st_d.bank[st_q.pend_idx].ext  = st_q.pend.ext;
                st_d.bank[st_q.pend_idx].id   = st_q.pend.id;
                st_d.pend_vld                 = 1'b0;
            end
            if (host_wr_en_i) begin
                st_d.bank[host_wr_idx_i].code = host_wr_code_i;
                st_d.bank[host_wr_idx_i].ext  = host_wr_ext_i;
                st_d.bank[host_wr_idx_i].id   = host_wr_id_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hit_o     = st_q.hit;
    assign miss_o    = st_q.miss;
    assign hit_idx_o = st_q.hit_idx;

    always_comb begin
        rd_ext_o  = st_q.bank[rd_idx_i].ext;
        rd_id_o   = st_q.bank[rd_idx_i].id;
        rd_dlc_o  = st_q.bank[rd_idx_i].dlc;
        rd_data_o = st_q.bank[rd_idx_i].data;
    end

endmodule

// File: rtl/rxmb_chk.sv
module rxmb_chk #(
    parameter  int NUM_BUF = 64,
    localparam int IW      = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 rx_valid_i,
    input logic                 rx_err_i,
    input logic [IW-1:0]        cfg_last_idx_i,
    input logic                 hit_o,
    input logic                 miss_o,
    input logic [IW-1:0]        hit_idx_o,
    input logic [NUM_BUF*4-1:0] buf_code_o
);

    // R11
    pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit_o && miss_o));

    // R11
    result_after_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid_i && !rx_err_i) |=> ##1 (hit_o || miss_o));

    // R2
    err_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid_i && rx_err_i) |=> ##1 !(hit_o || miss_o));

    // R2
    no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_o || miss_o) |-> $past(rx_valid_i && !rx_err_i, 2));

    // R9
    hit_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> (buf_code_o[{hit_idx_o, 2'b00} +: 4] == 4'b0010 ||
                   buf_code_o[{hit_idx_o, 2'b00} +: 4] == 4'b0110));

    // R4
    hit_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> (hit_idx_o <= $past(cfg_last_idx_i)));

    // R11
    miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        miss_o |-> $stable(buf_code_o));

endmodule

bind rx_mailbox_matcher rxmb_chk #(.NUM_BUF(NUM_BUF)) u_rxmb_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .rx_valid_i     (rx_valid_i),
    .rx_err_i       (rx_err_i),
    .cfg_last_idx_i (cfg_last_idx_i),
    .hit_o          (hit_o),
    .miss_o         (miss_o),
    .hit_idx_o      (hit_idx_o),
    .buf_code_o     (buf_code_o)
);

// File: tb/rx_mailbox_matcher_test.sv
`timescale 1ns/1ps
module rx_mailbox_matcher_test;

    localparam int NB = 64;
    localparam int IW = 6;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic            rst_n;
    logic [IW-1:0]   cfg_last_idx;
    logic            host_wr_en;
    logic [IW-1:0]   host_wr_idx;
    logic [3:0]      host_wr_code;
    logic            host_wr_ext;
    logic [28:0]     host_wr_id;
    logic            rx_valid, rx_err, rx_ext;
    logic [28:0]     rx_id;
    logic [3:0]      rx_dlc;
    logic [63:0]     rx_data;
    logic [IW-1:0]   rd_idx;
    logic            rd_ext;
    logic [28:0]     rd_id;
    logic [3:0]      rd_dlc;
    logic [63:0]     rd_data;
    logic            hit, miss;
    logic [IW-1:0]   hit_idx;
    logic [NB*4-1:0] buf_code;

    rx_mailbox_matcher #(.NUM_BUF(NB)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_last_idx_i(cfg_last_idx),
        .host_wr_en_i(host_wr_en), .host_wr_idx_i(host_wr_idx), .host_wr_code_i(host_wr_code),
        .host_wr_ext_i(host_wr_ext), .host_wr_id_i(host_wr_id),
        .rx_valid_i(rx_valid), .rx_err_i(rx_err), .rx_ext_i(rx_ext), .rx_id_i(rx_id),
        .rx_dlc_i(rx_dlc), .rx_data_i(rx_data), .rd_idx_i(rd_idx),
        .rd_ext_o(rd_ext), .rd_id_o(rd_id), .rd_dlc_o(rd_dlc), .rd_data_o(rd_data),
        .hit_o(hit), .miss_o(miss), .hit_idx_o(hit_idx), .buf_code_o(buf_code)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    // reference model of the mailboxes
    logic [3:0]  m_code [NB];
    logic        m_ext  [NB];
    logic [28:0] m_id   [NB];
    logic [3:0]  m_dlc  [NB];
    logic [63:0] m_data [NB];
    int          m_last;

    typedef struct {
        bit    hit;
        int    idx;
        string req;
    } exp_t;
    exp_t sbq[$];

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int model_find(input bit ext, input logic [28:0] id);
        for (int i = 0; i <= m_last; i++) begin
            if ((m_code[i] == 4'b0100 || m_code[i] == 4'b0010 || m_code[i] == 4'b0110) &&
                m_ext[i] == ext &&
                (ext ? (m_id[i] == id) : (m_id[i][28:18] == id[28:18])))
                return i;
        end
        return -1;
    endfunction

    function automatic void model_store(input int w, input logic [28:0] id,
                                        input logic [3:0] dlc, input logic [63:0] data);
        m_code[w] = (m_code[w] == 4'b0100) ? 4'b0010 : 4'b0110;
        m_id[w]   = id;
        m_dlc[w]  = dlc;
        m_data[w] = data;
    endfunction

    // monitor: pop and compare every result pulse
    always @(negedge clk) begin
        if (rst_n && (hit || miss)) begin
            if (sbq.size() == 0) begin
                check(1'b0, "R2", "unexpected result pulse", {62'd0, hit, miss}, 64'd0);
            end else begin
                exp_t e;
                e = sbq.pop_front();
                check(hit == e.hit, e.req, "hit flag", 64'(hit), 64'(e.hit));
                check(miss == !e.hit, e.req, "miss flag", 64'(miss), 64'(!e.hit));
                if (e.hit)
                    check(hit_idx == IW'(e.idx), e.req, "hit index", 64'(hit_idx), 64'(e.idx));
            end
        end
    end

    task automatic host_write(input int idx, input logic [3:0] code, input bit ext,
                              input logic [28:0] id);
        @(negedge clk);
        host_wr_en = 1; host_wr_idx = IW'(idx); host_wr_code = code;
        host_wr_ext = ext; host_wr_id = id;
        @(negedge clk);
        host_wr_en = 0;
        m_code[idx] = code; m_ext[idx] = ext; m_id[idx] = id;
    endtask

    task automatic set_limit(input int last);
        @(negedge clk);
        cfg_last_idx = IW'(last);
        m_last = last;
    endtask

    task automatic check_codes(input string req);
        int bad;
        bad = 0;
        #1;
        for (int i = 0; i < NB; i++) if (buf_code[i*4 +: 4] != m_code[i]) bad++;
        check(bad == 0, req, "mailbox codes mismatching", 64'(bad), 64'd0);
    endtask

    task automatic check_buf(input int idx, input string req);
        rd_idx = IW'(idx);
        #1;
        check(buf_code[idx*4 +: 4] == m_code[idx], req, "code", 64'(buf_code[idx*4 +: 4]), 64'(m_code[idx]));
        check(rd_id == m_id[idx], req, "stored id", 64'(rd_id), 64'(m_id[idx]));
        check(rd_dlc == m_dlc[idx], req, "stored dlc", 64'(rd_dlc), 64'(m_dlc[idx]));
        check(rd_data == m_data[idx], req, "stored data", rd_data, m_data[idx]);
    endtask

    task automatic send_frame(input bit err, input bit ext, input logic [28:0] id,
                              input logic [3:0] dlc, input logic [63:0] data, input string req);
        int w;
        if (!err) begin
            exp_t e;
            w = model_find(ext, id);
            e.hit = (w >= 0); e.idx = w; e.req = req;
            sbq.push_back(e);
            if (w >= 0) model_store(w, id, dlc, data);
        end
        @(negedge clk);
        rx_valid = 1; rx_err = err; rx_ext = ext; rx_id = id; rx_dlc = dlc; rx_data = data;
        @(negedge clk);
        rx_valid = 0; rx_err = 0;
        @(negedge clk);
        #1;
        if (err)
            check(!hit && !miss, "R2", "pulse after error frame", {62'd0, hit, miss}, 64'd0);
        check(sbq.size() == 0, "R11", "result not on expected cycle", 64'(sbq.size()), 64'd0);
        @(negedge clk);
        #1;
        check(!hit && !miss, "R11", "pulse longer than one cycle", {62'd0, hit, miss}, 64'd0);
    endtask

    localparam logic [28:0] ID_A = {11'h155, 18'h00000};
    localparam logic [28:0] ID_B = {11'h0F0, 18'h00000};
    localparam logic [28:0] ID_C = {11'h0E1, 18'h00000};
    localparam logic [28:0] ID_D = {11'h3C3, 18'h00000};
    localparam logic [28:0] ID_E = {11'h011, 18'h00000};
    localparam logic [28:0] ID_X = 29'h1234_5678;
    localparam logic [28:0] ID_Y = 29'h0ABC_DEF1;

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL R11 watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        rst_n = 0; cfg_last_idx = '1; host_wr_en = 0; host_wr_idx = '0; host_wr_code = '0;
        host_wr_ext = 0; host_wr_id = '0; rx_valid = 0; rx_err = 0; rx_ext = 0;
        rx_id = '0; rx_dlc = '0; rx_data = '0; rd_idx = '0;
        m_last = NB - 1;
        for (int i = 0; i < NB; i++) begin
            m_code[i] = 4'b0000; m_ext[i] = 0; m_id[i] = '0; m_dlc[i] = '0; m_data[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        #1;
        // R1 reset state
        check(buf_code == '0, "R1", "codes after reset", 64'(buf_code[63:0]), 64'd0);
        check(!hit && !miss, "R1", "pulses after reset", {62'd0, hit, miss}, 64'd0);

        host_write(3,  4'b0100, 0, ID_A);
        host_write(7,  4'b0100, 0, ID_A);
        host_write(10, 4'b0100, 1, ID_X);
        host_write(12, 4'b1100, 0, ID_B);
        host_write(14, 4'b0000, 0, ID_C);
        host_write(20, 4'b0100, 1, ID_Y);
        host_write(40, 4'b0100, 0, ID_D);
        host_write(50, 4'b0100, 0, ID_E);
        check_codes("R12");

        // R5 R6: low 18 bits differ, two candidates, lowest wins
        send_frame(0, 0, ID_A | 29'h2A5A5, 4'd8, 64'h0123_4567_89AB_CDEF, "R5");
        check_buf(3, "R10");
        check_codes("R9");
        send_frame(0, 0, ID_A | 29'h00001, 4'd3, 64'h0000_0000_00AA_BBCC, "R6");
        check_buf(3, "R9");
        send_frame(0, 0, ID_A | 29'h3FFFF, 4'd1, 64'h0000_0000_0000_0055, "R9");
        check_buf(3, "R9");
        // R6: upper bit differs by one
        send_frame(0, 0, ID_A ^ {11'h001, 18'h0}, 4'd2, 64'h1111, "R6");
        check_codes("R11");

        // R7 extended
        send_frame(0, 1, ID_X, 4'd4, 64'hDEAD_BEEF, "R7");
        check_buf(10, "R7");
        send_frame(0, 1, ID_X ^ 29'h1, 4'd4, 64'h1234, "R7");
        check_codes("R7");

        // R8 format flag
        send_frame(0, 1, ID_A, 4'd2, 64'h2222, "R8");
        send_frame(0, 0, ID_Y, 4'd2, 64'h3333, "R8");
        check_codes("R8");

        // R3 transmit and inactive mailboxes
        send_frame(0, 0, ID_B, 4'd2, 64'h4444, "R3");
        send_frame(0, 0, ID_C, 4'd2, 64'h5555, "R3");
        check_codes("R3");

        // R4 limit
        set_limit(30);
        send_frame(0, 0, ID_D, 4'd6, 64'h6666, "R4");
        set_limit(39);
        send_frame(0, 0, ID_D, 4'd6, 64'h7777, "R4");
        set_limit(40);
        send_frame(0, 0, ID_D, 4'd6, 64'h8888_9999, "R4");
        check_buf(40, "R4");
        set_limit(63);

        // R2 error frame
        send_frame(1, 0, ID_D, 4'd5, 64'hBAD0_BAD0, "R2");
        check_buf(40, "R2");
        check_codes("R2");

        // R12 host write together with a matching frame
        begin
            exp_t e;
            e.hit = 1; e.idx = 20; e.req = "R12";
            sbq.push_back(e);
            model_store(20, ID_Y, 4'd7, 64'hCAFE_F00D);
            @(negedge clk);
            rx_valid = 1; rx_err = 0; rx_ext = 1; rx_id = ID_Y; rx_dlc = 4'd7; rx_data = 64'hCAFE_F00D;
            host_wr_en = 1; host_wr_idx = IW'(20); host_wr_code = 4'b0000;
            host_wr_ext = 1; host_wr_id = ID_Y;
            @(negedge clk);
            rx_valid = 0; host_wr_en = 0;
            @(negedge clk);
            #1;
            check(sbq.size() == 0, "R12", "search saw deferred write", 64'(sbq.size()), 64'd0);
            check(buf_code[20*4 +: 4] == 4'b0010, "R12", "code right after search",
                  64'(buf_code[20*4 +: 4]), 64'h2);
            @(negedge clk);
            #1;
            m_code[20] = 4'b0000;
            check(buf_code[20*4 +: 4] == 4'b0000, "R12", "deferred write applied",
                  64'(buf_code[20*4 +: 4]), 64'h0);
            check_buf(20, "R10");
        end

        // R11 back-to-back strobes into the same mailbox
        begin
            exp_t e;
            e.hit = 1; e.idx = 50; e.req = "R11";
            sbq.push_back(e);
            model_store(50, ID_E | 29'h11, 4'd1, 64'hA1);
            sbq.push_back(e);
            model_store(50, ID_E | 29'h22, 4'd2, 64'hB2B2);
            @(negedge clk);
            rx_valid = 1; rx_err = 0; rx_ext = 0; rx_id = ID_E | 29'h11; rx_dlc = 4'd1; rx_data = 64'hA1;
            @(negedge clk);
            rx_id = ID_E | 29'h22; rx_dlc = 4'd2; rx_data = 64'hB2B2;
            @(negedge clk);
            rx_valid = 0;
            repeat (2) @(negedge clk);
            #1;
            check(sbq.size() == 0, "R11", "back-to-back results", 64'(sbq.size()), 64'd0);
            check_buf(50, "R9");
            check_codes("R11");
        end

        repeat (3) @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule